// File: doc/BRIEF.md
# Flash Write-Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash device, modelled on a synchronous internal bus. Each cycle with `wr_en` high presents one byte-write (address and data). The decoder checks these writes against the unlock keys and the command codes. When a sequence is complete it programs a byte, erases the whole array, sets a permanent protection latch on the lowest locations, or switches an identification mode on or off. It holds a small parameterised byte array internally.

Reads are taken on `rd_en` and return one of three things. Normally they return array contents. In identification mode they return fixed ID bytes. While an external operation timer holds `busy` high, they return a status byte that shows completion. `prog_req` and `erase_req` are one-cycle launch pulses that start that timer. Array location = low `log2(MEM_DEPTH)` address bits; the protected region is the first `BOOT_DEPTH` locations.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every command begins with data 0xAA written to address 0x5555, then 0x55 written to 0x2AAA. Command addresses compare only address bits 14:0, so bits above 14 do not affect decoding.
- R2: A third write of 0xA0 to 0x5555 arms a byte program. The next write, to any address, stores old AND new data at that location. `prog_req` is high in the cycle after that write.
- R3: Chip erase is six writes: the unlock pair, 0x80 to 0x5555, the unlock pair again, then 0x10 to 0x5555. Every unprotected location reads 0xFF afterwards, and `erase_req` is high in the cycle after the last write. `prog_req` and `erase_req` are never high together.
- R4: The same six-write form ending in 0x40 sets the protection latch. The latch stays set until reset.
- R5: While the latch is set, a program aimed at one of the first `BOOT_DEPTH` locations changes nothing and gives no `prog_req`. A chip erase leaves those locations intact.
- R6: A third write of 0x90 to 0x5555 enters identification mode. In that mode a read of address 0 returns 0x1F, address 1 returns 0x17, address 2 returns the protection latch in bit 0, and any other address returns 0x00.
- R7: Identification mode ends with the unlock pair followed by 0xF0 to 0x5555. It also ends with a single write of 0xF0 to any address while no sequence is in progress.
- R8: A write that does not match the expected step returns the decoder to idle. Such a write changes no location and raises no request.
- R9: Writes taken while `busy` is high are ignored. They do not advance a sequence and do not change the array.
- R10: A read while `busy` is high returns a status byte. Bit 7 is the inverse of bit 7 of the last programmed byte (0 after an erase). Bit 6 flips on every such read, starting from 0 after reset. Bits 5:0 are 0.
- R11: Reset gives an all-0xFF array, `rdata` = 0, no requests, no latch and no identification mode. A read returns its data in the cycle after `rd_en`, and `rdata` holds when `rd_en` is low. When `wr_en` and `rd_en` are both high, the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte-write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Cycle address |
| wdata | input | DATA_W | Write data |
| busy | input | 1 | Operation timer running |
| rdata | output | DATA_W | Registered read data |
| prog_req | output | 1 | Byte program launched |
| erase_req | output | 1 | Chip erase launched |

## Verification
Programs aimed at the same byte several times show that old and new data are ANDed rather than overwritten. Unlock writes carrying high address bits show that the compare uses only the low 15 bits. Directed broken sequences, and random streams of programs, reads and aborted unlocks, separate a decoder that really resets to idle from one that keeps partial progress. Runs with and without the protection latch, with both ID exit forms and with busy-time reads, separate the protected and unprotected paths, the two ways of leaving identification mode and the status byte from the array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   localparam int CMD_AW = 15;

   typedef enum logic [2:0] {
      S_IDLE, S_KEY1, S_KEY2, S_ARMED, S_EXT1, S_EXT2, S_EXT3
   } seq_state_e;

   localparam logic [CMD_AW-1:0] ADR_KEY_A = 15'h5555;
   localparam logic [CMD_AW-1:0] ADR_KEY_B = 15'h2AAA;

   localparam logic [7:0] KEY_A     = 8'hAA;
   localparam logic [7:0] KEY_B     = 8'h55;
   localparam logic [7:0] OP_PROG   = 8'hA0;
   localparam logic [7:0] OP_EXT    = 8'h80;
   localparam logic [7:0] OP_ID_ON  = 8'h90;
   localparam logic [7:0] OP_ID_OFF = 8'hF0;
   localparam logic [7:0] OP_ERASE  = 8'h10;
   localparam logic [7:0] OP_LOCK   = 8'h40;
   localparam logic [7:0] ID_MAKER  = 8'h1F;
   localparam logic [7:0] ID_PART   = 8'h17;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm import flash_cmd_pkg::*; #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              do_prog,
   output logic              do_erase,
   output logic              do_lock,
   output logic              id_enter,
   output logic              id_leave
);
   seq_state_e state_q, state_d;
   logic       hit_a, hit_b;

   assign hit_a = (addr[CMD_AW-1:0] == ADR_KEY_A);
   assign hit_b = (addr[CMD_AW-1:0] == ADR_KEY_B);

   always_comb begin
      state_d  = state_q;
      do_prog  = 1'b0;
      do_erase = 1'b0;
      do_lock  = 1'b0;
      id_enter = 1'b0;
      id_leave = 1'b0;
      if (wr_go) begin
         state_d = S_IDLE;
         unique case (state_q)
            S_IDLE: begin
               if (hit_a && wdata == KEY_A) state_d = S_KEY1;
               else if (wdata == OP_ID_OFF) id_leave = 1'b1;
            end
            S_KEY1: if (hit_b && wdata == KEY_B) state_d = S_KEY2;
            S_KEY2: begin
               if (hit_a) begin
                  unique case (wdata)
                     OP_PROG:   state_d  = S_ARMED;
                     OP_EXT:    state_d  = S_EXT1;
                     OP_ID_ON:  id_enter = 1'b1;
                     OP_ID_OFF: id_leave = 1'b1;
                     default:   ;
                  endcase
               end
            end
            S_ARMED: do_prog = 1'b1;
            S_EXT1:  if (hit_a && wdata == KEY_A) state_d = S_EXT2;
            S_EXT2:  if (hit_b && wdata == KEY_B) state_d = S_EXT3;
            S_EXT3: begin
               if (hit_a && wdata == OP_ERASE) do_erase = 1'b1;
               else if (hit_a && wdata == OP_LOCK) do_lock = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
   parameter int DEPTH      = 64,
   parameter int BOOT_DEPTH = 16,
   parameter int DATA_W     = 8,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic [AW-1:0]     prog_idx,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              erase_en,
   input  logic              locked,
   input  logic [AW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  keep;

   for (genvar i = 0; i < DEPTH; i++) begin : g_keep
      if (i < BOOT_DEPTH) begin : g_boot
         assign keep[i] = locked;
      end else begin : g_main
         assign keep[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (erase_en && !keep[i])
               cells[i] <= '1;
            else if (prog_en && prog_idx == AW'(i))
               cells[i] <= cells[i] & prog_data;
         end
      end
   end

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path import flash_cmd_pkg::*; #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic              busy,
   input  logic              id_mode,
   input  logic              locked,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [DATA_W-1:0] last_data,
   output logic [DATA_W-1:0] rdata
);
   logic toggle_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         toggle_q <= 1'b0;
      end else if (rd_go) begin
         if (busy) begin
            rdata    <= {~last_data[DATA_W-1], toggle_q, {(DATA_W-2){1'b0}}};
            toggle_q <= ~toggle_q;
         end else if (id_mode) begin
            if (addr == ADDR_W'(0))      rdata <= ID_MAKER;
            else if (addr == ADDR_W'(1)) rdata <= ID_PART;
            else if (addr == ADDR_W'(2)) rdata <= {{(DATA_W-1){1'b0}}, locked};
            else                         rdata <= '0;
         end else begin
            rdata <= arr_data;
         end
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import flash_cmd_pkg::*; #(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int MEM_DEPTH  = 64,
   parameter int BOOT_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   output logic [DATA_W-1:0] rdata,
   output logic              prog_req,
   output logic              erase_req
);
   localparam int MEM_AW = $clog2(MEM_DEPTH);
   localparam logic [MEM_AW:0] BOOT_LIM = (MEM_AW+1)'(BOOT_DEPTH);

   initial begin
      assert (DATA_W == 8) else $error("command codes need 8-bit data");
      assert (ADDR_W >= CMD_AW && ADDR_W >= MEM_AW) else $error("address too narrow");
      assert ((1 << MEM_AW) == MEM_DEPTH) else $error("MEM_DEPTH must be a power of two");
      assert (BOOT_DEPTH > 0 && BOOT_DEPTH <= MEM_DEPTH) else $error("bad BOOT_DEPTH");
   end

   logic              wr_go, rd_go;
   logic              do_prog, do_erase, do_lock, id_enter, id_leave;
   logic              lock_q, id_q, prog_ok, in_boot;
   logic [MEM_AW-1:0] idx;
   logic [DATA_W-1:0] last_q, arr_data;

   assign wr_go   = wr_en & ~busy;
   assign rd_go   = rd_en & ~wr_en;
   assign idx     = addr[MEM_AW-1:0];
   assign in_boot = ({1'b0, idx} < BOOT_LIM);
   assign prog_ok = do_prog & ~(lock_q & in_boot);

   flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .addr(addr), .wdata(wdata),
      .do_prog(do_prog), .do_erase(do_erase), .do_lock(do_lock),
      .id_enter(id_enter), .id_leave(id_leave)
   );

   flash_byte_array #(.DEPTH(MEM_DEPTH), .BOOT_DEPTH(BOOT_DEPTH), .DATA_W(DATA_W)) i_array (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_ok), .prog_idx(idx),
      .prog_data(wdata), .erase_en(do_erase), .locked(lock_q),
      .rd_idx(idx), .rd_data(arr_data)
   );

   flash_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_read (
      .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .busy(busy), .id_mode(id_q),
      .locked(lock_q), .addr(addr), .arr_data(arr_data), .last_data(last_q),
      .rdata(rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q    <= 1'b0;
         id_q      <= 1'b0;
         last_q    <= '1;
         prog_req  <= 1'b0;
         erase_req <= 1'b0;
      end else begin
         if (do_lock)       lock_q <= 1'b1;
         if (id_enter)      id_q   <= 1'b1;
         else if (id_leave) id_q   <= 1'b0;
         if (prog_ok)       last_q <= wdata;
         else if (do_erase) last_q <= '1;
         prog_req  <= prog_ok;
         erase_req <= do_erase;
      end
   end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int MEM_DEPTH  = 64,
   parameter int BOOT_DEPTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              busy,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rdata,
   input logic              prog_req,
   input logic              erase_req,
   input logic              lock_q,
   input logic              id_q
);
   localparam int MEM_AW = $clog2(MEM_DEPTH);
   localparam logic [MEM_AW:0] BOOT_LIM = (MEM_AW+1)'(BOOT_DEPTH);

   assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_req && erase_req));

   assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> (!prog_req && !erase_req));

   assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   assert_boot_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !($past(lock_q) && ({1'b0, $past(addr[MEM_AW-1:0])} < BOOT_LIM)));

   assert_status_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && busy) |=> (rdata[DATA_W-3:0] == '0));

   assert_id_maker_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !busy && id_q && addr == '0) |=> (rdata == 8'h1F));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && $past(rst_n)) |=> $stable(rdata));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .BOOT_DEPTH(BOOT_DEPTH)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .busy(busy),
   .addr(addr), .rdata(rdata), .prog_req(prog_req), .erase_req(erase_req),
   .lock_q(lock_q), .id_q(id_q)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        prog_req, erase_req;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0] mdl [64];
   bit         mlock, mid, mtog;
   logic [7:0] mlast;

   always #2.5 clk = ~clk;

   flash_cmd_decoder i_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .busy(busy), .rdata(rdata), .prog_req(prog_req),
      .erase_req(erase_req)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic do_wr(input logic [16:0] a, input logic [7:0] d, output bit pr, output bit er);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      pr = prog_req; er = erase_req;
   endtask

   task automatic do_rd(input logic [16:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic [7:0] exp_idle_read(input logic [16:0] a);
      if (mid) begin
         if (a == 17'd0) return 8'h1F;
         if (a == 17'd1) return 8'h17;
         if (a == 17'd2) return {7'b0, mlock};
         return 8'h00;
      end
      return mdl[a[5:0]];
   endfunction

   task automatic rd_chk(input logic [16:0] a, input string req);
      logic [7:0] got, exp;
      if (busy) begin
         exp  = {~mlast[7], mtog, 6'b0};
         mtog = ~mtog;
      end else begin
         exp = exp_idle_read(a);
      end
      do_rd(a, got);
      check(req, got, exp);
   endtask

   task automatic unlock(input logic [1:0] hi, input string req);
      bit pr, er;
      do_wr({hi, 15'h5555}, 8'hAA, pr, er);
      check(req, {6'b0, pr, er}, 8'h00);
      do_wr({hi, 15'h2AAA}, 8'h55, pr, er);
      check(req, {6'b0, pr, er}, 8'h00);
   endtask

   task automatic cmd_prog(input logic [1:0] hi, input logic [16:0] a, input logic [7:0] d,
                           input string req);
      bit pr, er, ok;
      unlock(hi, req);
      do_wr({hi, 15'h5555}, 8'hA0, pr, er);
      do_wr(a, d, pr, er);
      ok = !busy && !(mlock && a[5:0] < 6'd16);
      check(req, {6'b0, pr, er}, {6'b0, ok, 1'b0});
      if (ok) begin
         mdl[a[5:0]] = mdl[a[5:0]] & d;
         mlast = d;
      end
   endtask

   task automatic cmd_ext(input logic [7:0] fin, input string req);
      bit pr, er, go;
      unlock(2'b00, req);
      do_wr(17'h05555, 8'h80, pr, er);
      unlock(2'b00, req);
      do_wr(17'h05555, fin, pr, er);
      go = !busy && fin == 8'h10;
      check(req, {6'b0, pr, er}, {7'b0, go});
      if (!busy && fin == 8'h10) begin
         for (int i = 0; i < 64; i++)
            if (!(mlock && i < 16)) mdl[i] = 8'hFF;
         mlast = 8'hFF;
      end
      if (!busy && fin == 8'h40) mlock = 1'b1;
   endtask

   task automatic cmd_id(input logic [7:0] code, input string req);
      bit pr, er;
      unlock(2'b00, req);
      do_wr(17'h05555, code, pr, er);
      check(req, {6'b0, pr, er}, 8'h00);
      if (!busy && code == 8'h90) mid = 1'b1;
      if (!busy && code == 8'hF0) mid = 1'b0;
   endtask

   task automatic random_phase(input int n);
      bit pr, er;
      for (int k = 0; k < n; k++) begin
         int op;
         logic [16:0] a;
         logic [7:0]  d;
         op = $urandom_range(0, 2);
         a  = 17'($urandom);
         d  = 8'($urandom);
         case (op)
            0: cmd_prog(2'b00, a, d, "R2 random program");
            1: rd_chk(a, "R11 random read");
            default: begin
               do_wr(17'h05555, 8'hAA, pr, er);
               do_wr(17'h02AAA, 8'h55 ^ 8'($urandom_range(1, 255)), pr, er);
               check("R8 random broken unlock", {6'b0, pr, er}, 8'h00);
               rd_chk(a, "R8 read after broken unlock");
            end
         endcase
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit pr, er;
      logic [7:0] got;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
      mlock = 1'b0; mid = 1'b0; mtog = 1'b0; mlast = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check("R11 reset rdata", rdata, 8'h00);
      check("R11 reset requests", {6'b0, prog_req, erase_req}, 8'h00);
      rd_chk(17'h00005, "R11 erased after reset");
      do_rd(17'h00005, got);
      @(negedge clk);
      check("R11 rdata holds", rdata, 8'hFF);

      // R2 program and AND behaviour
      cmd_prog(2'b00, 17'h00040, 8'h5A, "R2 program");
      rd_chk(17'h00000, "R2 readback");
      cmd_prog(2'b00, 17'h00040, 8'h0F, "R2 second program");
      rd_chk(17'h00040, "R2 AND of old and new");

      // R1 upper address bits ignored in command compare
      cmd_prog(2'b11, 17'h00003, 8'h33, "R1 high address bits");
      rd_chk(17'h00003, "R1 readback");

      // R8 broken sequences
      do_wr(17'h05555, 8'hAA, pr, er);
      do_wr(17'h02AAB, 8'h55, pr, er);
      do_wr(17'h05555, 8'hA0, pr, er);
      do_wr(17'h00007, 8'h00, pr, er);
      check("R8 wrong unlock address", {6'b0, pr, er}, 8'h00);
      rd_chk(17'h00007, "R8 location untouched");
      unlock(2'b00, "R8 prefix");
      do_wr(17'h05555, 8'hA1, pr, er);
      do_wr(17'h00008, 8'h00, pr, er);
      check("R8 wrong code", {6'b0, pr, er}, 8'h00);
      rd_chk(17'h00008, "R8 location untouched after bad code");

      // R9 writes ignored while busy
      busy = 1'b1;
      cmd_prog(2'b00, 17'h00009, 8'h00, "R9 program while busy");
      mtog = 1'b0;
      busy = 1'b0;
      rd_chk(17'h00009, "R9 location unchanged");

      // R10 status reads
      cmd_prog(2'b00, 17'h0000A, 8'h3C, "R10 setup program");
      busy = 1'b1;
      rd_chk(17'h0000A, "R10 status read 1");
      rd_chk(17'h0000A, "R10 status read 2");
      rd_chk(17'h0000A, "R10 status read 3");
      busy = 1'b0;
      rd_chk(17'h0000A, "R10 data after busy");

      // R6 / R7 identification mode
      cmd_id(8'h90, "R6 enter");
      rd_chk(17'h00000, "R6 maker id");
      rd_chk(17'h00001, "R6 part id");
      rd_chk(17'h00002, "R6 lock bit clear");
      rd_chk(17'h00003, "R6 other address");
      do_wr(17'h01234, 8'hF0, pr, er);
      mid = 1'b0;
      rd_chk(17'h00000, "R7 single-write exit");
      cmd_id(8'h90, "R7 re-enter");
      cmd_id(8'hF0, "R7 three-write exit");
      rd_chk(17'h00001, "R7 array after exit");

      random_phase(150);

      // R3 chip erase without lock
      cmd_ext(8'h10, "R3 chip erase");
      rd_chk(17'h00000, "R3 erased low");
      rd_chk(17'h0003F, "R3 erased high");
      busy = 1'b1;
      rd_chk(17'h00000, "R10 status after erase");
      busy = 1'b0;

      // R4 lockout
      cmd_prog(2'b00, 17'h00002, 8'h11, "R5 boot setup");
      cmd_prog(2'b00, 17'h00020, 8'h22, "R5 main setup");
      cmd_ext(8'h40, "R4 lockout");
      cmd_id(8'h90, "R4 enter id");
      rd_chk(17'h00002, "R6 lock bit set");
      cmd_id(8'hF0, "R4 leave id");

      // R5 protection
      cmd_prog(2'b00, 17'h00002, 8'h00, "R5 boot program blocked");
      rd_chk(17'h00002, "R5 boot unchanged");
      cmd_prog(2'b00, 17'h00021, 8'h44, "R5 main program allowed");
      cmd_ext(8'h10, "R5 erase while locked");
      rd_chk(17'h00002, "R5 boot kept by erase");
      rd_chk(17'h00020, "R5 main erased");
      cmd_ext(8'h40, "R4 lock again");
      cmd_id(8'h90, "R4 id");
      rd_chk(17'h00002, "R4 lock still set");
      cmd_id(8'hF0, "R4 id exit");

      random_phase(150);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule